// File: doc/BRIEF.md
# Flag-producing 32-bit integer ALU

A purely combinational integer arithmetic unit for a small load/store processor core. It takes a 4-bit operation code and two operands, A and B. It returns a result word and a 2-bit status field that holds an overflow flag and a zero flag. There is no clock and no internal state: the outputs follow the inputs within one propagation delay.

The supported operations are add, subtract, unsigned set-less-than, the three bitwise operations, two logical shifts and an arithmetic right shift. The overflow flag has unsigned meaning. For add it is the carry out. For subtract it is the borrow. For every other operation it is zero. A shift uses only the low bits of B as its distance. Any opcode outside the map gives a zero result.

Top module: `flag_alu`

## Requirements
- R1: Opcode 4'b0000 (add) gives result = (A + B) mod 2^32, and the overflow flag is 1 exactly when the unsigned sum carries out of bit 31.
- R2: Opcode 4'b0001 (subtract) gives result = (A - B) mod 2^32, and the overflow flag is 1 exactly when A < B as unsigned values.
- R3: Opcode 4'b0011 (set-less-than) gives 32'd1 when A < B under an unsigned comparison, and 32'd0 otherwise.
- R4: Opcodes 4'b0100, 4'b0101 and 4'b0110 give the bitwise AND, OR and XOR of A and B respectively.
- R5: Opcode 4'b1000 shifts A left and opcode 4'b1001 shifts A right; both fill the vacated bits with zeros.
- R6: Opcode 4'b1011 shifts A right and copies bit 31 of A into every vacated bit. For example, 0xF0000000 shifted by 28 gives 0xFFFFFFFF.
- R7: For all shifts the distance is B[4:0]. Bits B[31:5] have no effect on the result.
- R8: The overflow flag is 0 for every opcode other than add and subtract.
- R9: The zero flag is 1 exactly when the 32-bit result is zero, for every opcode.
- R10: The status output is {overflow, zero}, with overflow in bit 1 and zero in bit 0.
- R11: Any opcode not listed above (2, 7, 10, 12 to 15) gives result 0 with overflow 0, so status reads 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand A; this is the value that is shifted |
| b_i | input | 32 | Operand B; its low 5 bits are the shift distance |
| result_o | output | 32 | Operation result |
| status_o | output | 2 | {overflow, zero} |

## Verification
The block has no state, so any fault shows at the ports in the same evaluation as the stimulus that exposes it. A wrong carry polarity or borrow polarity appears as a flipped status bit 1 on add or subtract operands that straddle the wrap point. A wrong shifter stage appears only for distances that use that stage, and a wrong fill bit appears only when bit 31 of A is set. For this reason the random operands are combined with directed distances, sign patterns and values of B whose upper bits are set.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned SHAMT_W = $clog2(DATA_W);

  typedef enum logic [3:0] {
    OP_ADD = 4'b0000,
    OP_SUB = 4'b0001,
    OP_SLT = 4'b0011,
    OP_AND = 4'b0100,
    OP_OR  = 4'b0101,
    OP_XOR = 4'b0110,
    OP_SLL = 4'b1000,
    OP_SRL = 4'b1001,
    OP_SRA = 4'b1011
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_XOR = 2'b10
  } logic_sel_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         flag_o
);
  logic [W-1:0] b_op;
  logic         c_out;

  assign b_op = sub_i ? ~b_i : b_i;
  assign {c_out, sum_o} = {1'b0, a_i} + {1'b0, b_op} + {{W{1'b0}}, sub_i};
  // carry for add, borrow for subtract
  assign flag_o = sub_i ? ~c_out : c_out;

  always_comb begin
    if (!$isunknown({a_i, b_i, sub_i, sum_o, flag_o})) begin
      if (!sub_i) AST_CARRY_OUT: assert (flag_o == (sum_o < b_i)); // R1
      if (sub_i)  AST_BORROW:    assert (flag_o == (a_i < b_i));   // R2
    end
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int unsigned W  = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [SW-1:0] shamt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [W-1:0]  res_o
);
  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < int'(W); i++) r[i] = v[W-1-i];
    return r;
  endfunction

  logic [SW:0][W-1:0] stage;
  logic               fill;

  // left shift runs through the right shifter on the bit-reversed word
  assign stage[0] = left_i ? rev(a_i) : a_i;
  assign fill     = arith_i & ~left_i & a_i[W-1];

  for (genvar k = 0; k < int'(SW); k++) begin : g_stage
    localparam int unsigned S = 2 ** k;
    assign stage[k+1] = shamt_i[k] ? {{S{fill}}, stage[k][W-1:S]} : stage[k];
  end

  assign res_o = left_i ? rev(stage[SW]) : stage[SW];

  always_comb begin
    if (!$isunknown({a_i, shamt_i, left_i, arith_i, res_o})) begin
      if (!left_i && shamt_i != '0)
        AST_RSHIFT_FILL: assert (res_o[W-1] == (arith_i & a_i[W-1])); // R6
      if (left_i && shamt_i != '0)
        AST_LSHIFT_FILL: assert (res_o[0] == 1'b0); // R5
      if (shamt_i == '0)
        AST_SHIFT_NONE: assert (res_o == a_i); // R7
    end
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
(
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic [1:0]        status_o
);
  alu_op_e           op;
  logic [DATA_W-1:0] as_sum, lg_res, sh_res;
  logic              as_flag, is_sub, sh_left, sh_arith, ovf, zero;
  logic_sel_e        lg_sel;

  assign op       = alu_op_e'(op_i);
  assign is_sub   = (op == OP_SUB) || (op == OP_SLT);
  assign sh_left  = (op == OP_SLL);
  assign sh_arith = (op == OP_SRA);
  assign lg_sel   = logic_sel_e'(op_i[1:0]);

  alu_addsub #(.W(DATA_W)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (is_sub),
    .sum_o (as_sum),
    .flag_o(as_flag)
  );

  alu_logic #(.W(DATA_W)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .sel_i(lg_sel),
    .res_o(lg_res)
  );

  alu_shift #(.W(DATA_W)) u_shift (
    .a_i    (a_i),
    .shamt_i(b_i[SHAMT_W-1:0]),
    .left_i (sh_left),
    .arith_i(sh_arith),
    .res_o  (sh_res)
  );

  always_comb begin
    result_o = '0;
    ovf      = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        result_o = as_sum;
        ovf      = as_flag;
      end
      OP_SLT:                 result_o = {{(DATA_W-1){1'b0}}, as_flag}; // borrow == unsigned less-than
      OP_AND, OP_OR, OP_XOR:  result_o = lg_res;
      OP_SLL, OP_SRL, OP_SRA: result_o = sh_res;
      default: ;
    endcase
  end

  assign zero     = (result_o == '0);
  assign status_o = {ovf, zero};

  always_comb begin
    if (!$isunknown({op_i, a_i, b_i, result_o, status_o})) begin
      if (op != OP_ADD && op != OP_SUB)
        AST_NO_OVERFLOW: assert (status_o[1] == 1'b0); // R8
      AST_ZERO_FLAG: assert (status_o[0] == ~|result_o); // R9
      if (op == OP_SLT)
        AST_SLT_RANGE: assert (result_o[DATA_W-1:1] == '0 && result_o[0] == (a_i < b_i)); // R3
      if (!(op inside {OP_ADD, OP_SUB, OP_SLT, OP_AND, OP_OR, OP_XOR, OP_SLL, OP_SRL, OP_SRA}))
        AST_UNUSED_OP: assert (result_o == '0 && status_o == 2'b01); // R11
    end
  end
endmodule

// File: tb/flag_alu_tb.sv
module flag_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op;
  logic [31:0] a, b, res;
  logic [1:0]  st;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  flag_alu u_dut (.op_i(op), .a_i(a), .b_i(b), .result_o(res), .status_o(st));

  function automatic logic [33:0] model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] r;
    logic        v;
    r = '0; v = 1'b0;
    case (o)
      4'b0000: begin r = x + y; v = r < y; end
      4'b0001: begin r = x - y; v = x < y; end
      4'b0011: r = (x < y) ? 32'd1 : 32'd0;
      4'b0100: r = x & y;
      4'b0101: r = x | y;
      4'b0110: r = x ^ y;
      4'b1000: r = x << y[4:0];
      4'b1001: r = x >> y[4:0];
      4'b1011: r = $unsigned($signed(x) >>> y[4:0]);
      default: r = '0;
    endcase
    return {r, v, (r == 32'd0)};
  endfunction

  task automatic chk(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y, input string tag);
    logic [33:0] e;
    @(negedge clk);
    op = o; a = x; b = y;
    #2;
    e = model(o, x, y);
    checks++;
    if ({res, st} !== e) begin
      errors++;
      $display("FAIL %s op=%h a=%h b=%h: result=%h status=%b expected result=%h status=%b",
               tag, o, x, y, res, st, e[33:2], e[1:0]);
    end
  endtask

  task automatic chk_exact(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                           input logic [31:0] er, input logic [1:0] es, input string tag);
    @(negedge clk);
    op = o; a = x; b = y;
    #2;
    checks++;
    if (res !== er || st !== es) begin
      errors++;
      $display("FAIL %s op=%h a=%h b=%h: result=%h status=%b expected result=%h status=%b",
               tag, o, x, y, res, st, er, es);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] ops [9] = '{4'h0, 4'h1, 4'h3, 4'h4, 4'h5, 4'h6, 4'h8, 4'h9, 4'hB};
    string      tags [9] = '{"R1", "R2", "R3", "R4", "R4", "R4", "R5", "R5", "R6"};
    logic [3:0] bad [7] = '{4'h2, 4'h7, 4'hA, 4'hC, 4'hD, 4'hE, 4'hF};
    void'($urandom(32'h1234_5678));
    op = '0; a = '0; b = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // all-zero inputs: add gives 0 with status 01 (R9, R10)
    chk_exact(4'h0, 32'h0, 32'h0, 32'h0, 2'b01, "R9_R10_zero_inputs");
    // carry out with zero result sets both flags (R1, R10)
    chk_exact(4'h0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 2'b11, "R1_R10_wrap");
    chk_exact(4'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 2'b10, "R1_carry");
    // equal operands: no borrow (R2)
    chk_exact(4'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 2'b01, "R2_equal");
    chk_exact(4'h1, 32'h0000_0001, 32'h0000_0002, 32'hFFFF_FFFF, 2'b10, "R2_borrow");
    // unsigned compare (R3)
    chk_exact(4'h3, 32'h8FFF_FFFF, 32'hFFFF_FFFF, 32'h1, 2'b00, "R3_lt");
    chk_exact(4'h3, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 2'b01, "R3_ge_unsigned");
    chk_exact(4'h3, 32'h0000_0005, 32'h0000_0005, 32'h0, 2'b01, "R3_equal");
    // bitwise extremes (R4)
    chk_exact(4'h4, 32'hFFFF_FFFF, 32'h0, 32'h0, 2'b01, "R4_and");
    chk_exact(4'h5, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, "R4_or");
    chk_exact(4'h6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 2'b01, "R4_xor");
    // shifts (R5, R6)
    chk_exact(4'h8, 32'h0000_000F, 32'd4, 32'h0000_00F0, 2'b00, "R5_sll");
    chk_exact(4'h8, 32'hFFFF_FFFF, 32'd28, 32'hF000_0000, 2'b00, "R5_sll_28");
    chk_exact(4'h9, 32'hF000_0000, 32'd28, 32'h0000_000F, 2'b00, "R5_srl");
    chk_exact(4'hB, 32'hF000_0000, 32'd28, 32'hFFFF_FFFF, 2'b00, "R6_sra_neg");
    chk_exact(4'hB, 32'h0000_000F, 32'd4, 32'h0, 2'b01, "R6_sra_pos");
    chk_exact(4'hB, 32'h8000_0000, 32'd31, 32'hFFFF_FFFF, 2'b00, "R6_sra_31");
    // upper bits of B ignored (R7)
    chk_exact(4'h8, 32'h0000_000F, 32'hFFFF_FFE4, 32'h0000_00F0, 2'b00, "R7_sll_upper");
    chk_exact(4'h9, 32'hF000_0000, 32'hABCD_EF3C, 32'h0000_000F, 2'b00, "R7_srl_upper");
    chk_exact(4'hB, 32'h8000_0000, 32'hFFFF_FFE0, 32'h8000_0000, 2'b00, "R7_sra_zero_dist");
    // no overflow on non-arithmetic ops (R8)
    chk_exact(4'h3, 32'h0, 32'hFFFF_FFFF, 32'h1, 2'b00, "R8_slt");
    chk_exact(4'h5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, "R8_or");
    // unused opcodes (R11)
    foreach (bad[i]) chk_exact(bad[i], 32'hDEAD_BEEF, 32'h1234_5678, 32'h0, 2'b01, "R11_unused");

    // random operands against the model
    foreach (ops[i]) begin
      for (int n = 0; n < 300; n++) chk(ops[i], $urandom, $urandom, tags[i]);
      for (int n = 0; n < 32; n++) chk(ops[i], $urandom, n, tags[i]);
    end
    for (int n = 0; n < 200; n++) chk(4'hB, $urandom | 32'h8000_0000, $urandom, "R6_rand_neg");
    for (int n = 0; n < 200; n++) chk(4'h0, $urandom, 32'hFFFF_FFFF - ($urandom & 32'hFF), "R1_rand_wrap");
    for (int n = 0; n < 100; n++) chk(4'($urandom), $urandom, $urandom, "R9_rand_any");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule